// File: doc/BRIEF.md
# Video Sync Event Interrupt Controller

This block gathers the event pulses of a parallel video capture path and turns them into one interrupt line for the processor. Four sources are watched: the end of a captured frame, the vertical sync, the horizontal sync and an overrun pulse from the output data FIFO. The two sync inputs arrive from the camera side without a known phase. Each one passes through a synchronizer chain and an edge detector, so every edge of a sync signal gives exactly one event pulse.

Every event sets a bit in a raw status register, whatever the enable setting. An enable register decides which raw bits show up in the masked interrupt status. The interrupt line is high while any masked bit is set. Software clears events by writing ones to a clear register. The vertical and horizontal events can each be placed on the leading edge (start of frame or line) or the trailing edge (end of frame or line). The frame-done event counts only while both capture and cropping are enabled.

The configuration inputs (capture enable, crop enable, edge selects) come from a control register elsewhere and are synchronous to `clk`. A sync input is high while its frame or line is active.

Top module: `vcap_irq_ctrl`

## Requirements
- R1: After reset, the raw status, enable and masked status registers read zero and `irq` is low.
- R2: The event bit positions are: bit 0 frame done, bit 1 FIFO overrun, bit 2 vertical sync, bit 3 horizontal sync. The word addresses are: 0 raw status (read-only), 1 enable (read/write, all DATA_W bits stored), 2 masked status (read-only), 3 clear (write-only, reads as zero). `reg_rdata` holds the addressed value one cycle after a `reg_re` strobe.
- R3: A raw status bit is set by its event regardless of the enable register. Writes to addresses 0 and 2 change nothing.
- R4: The masked status equals raw status AND enable[3:0]. `irq` is high exactly when the masked status is non-zero.
- R5: Writing a word to the clear address clears every event bit whose data bit is 1 and leaves every bit whose data bit is 0 unchanged.
- R6: With `cfg_vs_at_end`=0, a rising edge of `vsync_in` (frame start) sets bit 2. With `cfg_vs_at_end`=1, only a falling edge (frame end) sets it. The bit is visible SYNC_STAGES+1 cycles after the edge is first sampled.
- R7: `cfg_hs_at_end` selects the edge of `hsync_in` in the same way for bit 3. A level held for many cycles gives only one event.
- R8: A falling edge of `vsync_in` sets bit 0 only when both `cfg_cap_en` and `cfg_crop_en` are 1. Otherwise bit 0 stays clear.
- R9: `ovr_pulse` sets bit 1 in the same cycle it is sampled, but only while `cfg_cap_en` is 1.
- R10: When an event and a clear for the same bit fall in one cycle, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vsync_in | input | 1 | Vertical sync, high during the active frame, asynchronous |
| hsync_in | input | 1 | Horizontal sync, high during the active line, asynchronous |
| ovr_pulse | input | 1 | One-cycle FIFO overrun pulse, synchronous |
| cfg_cap_en | input | 1 | Capture enable |
| cfg_crop_en | input | 1 | Crop window enable |
| cfg_vs_at_end | input | 1 | 1: vertical event at frame end, 0: at frame start |
| cfg_hs_at_end | input | 1 | 1: horizontal event at line end, 0: at line start |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The embedded properties check on every cycle that:
- an event always leaves its bit set, even against a clear;
- a clear with no event drops the bit;
- the frame-done and overrun bits only rise under their gating configuration;
- each sync edge detector pulses for a single cycle.

Only the bench scenarios can show the rest:
- which sync edge each select setting picks, and the synchronizer latency;
- that writes to the read-only addresses change nothing;
- the masking into the interrupt status and the interrupt line;
- the read-back values of the register map.

// File: rtl/vcap_irq_pkg.sv
package vcap_irq_pkg;
   localparam int NUM_EVT   = 4;
   // event bit positions inside every status word
   localparam int EV_FDONE  = 0;
   localparam int EV_OVR    = 1;
   localparam int EV_VS     = 2;
   localparam int EV_HS     = 3;
   // word addresses
   localparam int ADR_RAW   = 0;
   localparam int ADR_ENA   = 1;
   localparam int ADR_MASK  = 2;
   localparam int ADR_CLR   = 3;
endpackage

// File: rtl/vcap_sync_edge.sv
module vcap_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;
   logic              level;

   generate
      if (STAGES < 2) begin : g_bad
         $error("vcap_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_in};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign level = chain_q[STAGES-1];
   assign rise  = level & ~prev_q;
   assign fall  = ~level & prev_q;

   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);  // R7
   AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);  // R7
endmodule

// File: rtl/vcap_evt_reg.sv
module vcap_evt_reg #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt,
   input  logic [N-1:0] clr,
   output logic [N-1:0] raw
);
   logic [N-1:0] raw_q;

   // a fresh event outranks a clear of the same bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_q <= '0;
      else        raw_q <= evt | (raw_q & ~clr);
   end

   assign raw = raw_q;

   generate
      for (genvar i = 0; i < N; i++) begin : g_chk
         AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> raw_q[i]);  // R10
         AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !evt[i]) |=> !raw_q[i]);  // R5
      end
   endgenerate
endmodule

// File: rtl/vcap_irq_ctrl.sv
module vcap_irq_ctrl
   import vcap_irq_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vsync_in,
   input  logic              hsync_in,
   input  logic              ovr_pulse,
   input  logic              cfg_cap_en,
   input  logic              cfg_crop_en,
   input  logic              cfg_vs_at_end,
   input  logic              cfg_hs_at_end,
   input  logic              reg_we,
   input  logic              reg_re,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   localparam int PAD_W = DATA_W - NUM_EVT;

   generate
      if (DATA_W <= NUM_EVT) begin : g_bad_dw
         $error("vcap_irq_ctrl: DATA_W must exceed the event count");
      end
      if (ADDR_W < 2) begin : g_bad_aw
         $error("vcap_irq_ctrl: ADDR_W must be at least 2");
      end
   endgenerate

   logic               vs_rise, vs_fall, hs_rise, hs_fall;
   logic [NUM_EVT-1:0] evt, clr, raw, masked;
   logic [DATA_W-1:0]  ena_q, rd_mux;
   logic               hit_ena, hit_clr;

   vcap_sync_edge #(.STAGES(SYNC_STAGES)) u_vs (
      .clk(clk), .rst_n(rst_n), .async_in(vsync_in),
      .rise(vs_rise), .fall(vs_fall));

   vcap_sync_edge #(.STAGES(SYNC_STAGES)) u_hs (
      .clk(clk), .rst_n(rst_n), .async_in(hsync_in),
      .rise(hs_rise), .fall(hs_fall));

   always_comb begin
      evt           = '0;
      evt[EV_FDONE] = vs_fall & cfg_cap_en & cfg_crop_en;
      evt[EV_OVR]   = ovr_pulse & cfg_cap_en;
      evt[EV_VS]    = cfg_vs_at_end ? vs_fall : vs_rise;
      evt[EV_HS]    = cfg_hs_at_end ? hs_fall : hs_rise;
   end

   assign hit_ena = reg_we && (reg_addr == ADDR_W'(ADR_ENA));
   assign hit_clr = reg_we && (reg_addr == ADDR_W'(ADR_CLR));
   assign clr     = hit_clr ? reg_wdata[NUM_EVT-1:0] : '0;

   vcap_evt_reg #(.N(NUM_EVT)) u_evt (
      .clk(clk), .rst_n(rst_n), .evt(evt), .clr(clr), .raw(raw));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ena_q <= '0;
      else if (hit_ena) ena_q <= reg_wdata;
   end

   assign masked = raw & ena_q[NUM_EVT-1:0];
   assign irq    = |masked;

   always_comb begin
      case (reg_addr)
         ADDR_W'(ADR_RAW):  rd_mux = {{PAD_W{1'b0}}, raw};
         ADDR_W'(ADR_ENA):  rd_mux = ena_q;
         ADDR_W'(ADR_MASK): rd_mux = {{PAD_W{1'b0}}, masked};
         default:           rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_re) reg_rdata <= rd_mux;
   end

   AST_FDONE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw[EV_FDONE]) |-> $past(cfg_cap_en && cfg_crop_en));  // R8
   AST_OVR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw[EV_OVR]) |-> $past(cfg_cap_en));  // R9
   AST_ENA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_ena |=> $stable(ena_q));  // R2
endmodule

// File: tb/vcap_irq_ctrl_bench.sv
module vcap_irq_ctrl_bench;
   localparam int AW = 4;
   localparam int DW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vsync_in = 1'b0, hsync_in = 1'b0, ovr_pulse = 1'b0;
   logic cap = 1'b0, crop = 1'b0, vs_end = 1'b0, hs_end = 1'b0;
   logic we = 1'b0, re = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic irq;

   always #4 clk = ~clk;

   vcap_irq_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2)) u_vcap_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .hsync_in(hsync_in),
      .ovr_pulse(ovr_pulse), .cfg_cap_en(cap), .cfg_crop_en(crop),
      .cfg_vs_at_end(vs_end), .cfg_hs_at_end(hs_end),
      .reg_we(we), .reg_re(re), .reg_addr(addr), .reg_wdata(wdata),
      .reg_rdata(rdata), .irq(irq));

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   typedef struct {
      logic [DW-1:0] exp;
      string         tag;
   } item_t;
   item_t exp_q[$];

   logic re_q = 1'b0;
   always @(posedge clk) re_q <= re;

   // monitor: compares each completed read with the oldest expected item
   always @(negedge clk) begin
      if (re_q) begin
         total++;
         if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL unexpected read: actual=%h expected=none", rdata);
         end else begin
            item_t it;
            it = exp_q.pop_front();
            if (rdata !== it.exp) begin
               bad++;
               $display("FAIL %s: actual=%h expected=%h", it.tag, rdata, it.exp);
            end
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd(input int a, input logic [DW-1:0] e, input string tag);
      item_t it;
      @(negedge clk);
      it.exp = e;
      it.tag = tag;
      exp_q.push_back(it);
      re   = 1'b1;
      addr = AW'(a);
      @(negedge clk);
      re   = 1'b0;
   endtask

   task automatic wr(input int a, input logic [DW-1:0] d);
      @(negedge clk);
      we = 1'b1; addr = AW'(a); wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic chk_irq(input logic e, input string tag);
      @(negedge clk);
      total++;
      if (irq !== e) begin
         bad++;
         $display("FAIL %s: irq actual=%b expected=%b", tag, irq, e);
      end
   endtask

   task automatic set_vs(input logic v);
      @(negedge clk);
      vsync_in = v;
      idle(5);
   endtask

   task automatic set_hs(input logic v);
      @(negedge clk);
      hsync_in = v;
      idle(5);
   endtask

   task automatic pulse_ovr();
      @(negedge clk);
      ovr_pulse = 1'b1;
      @(negedge clk);
      ovr_pulse = 1'b0;
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      #(8 * 100000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      idle(4);
      rst_n = 1'b1;
      // R1 reset state
      rd(0, 32'h0, "R1 raw after reset");
      rd(1, 32'h0, "R1 enable after reset");
      rd(2, 32'h0, "R1 masked after reset");
      chk_irq(1'b0, "R1 irq after reset");

      // R3 / R6: frame start recorded with everything disabled
      set_vs(1'b1);
      rd(0, 32'h4, "R6 vsync rise at frame start");
      rd(2, 32'h0, "R3 masked stays clear when disabled");
      chk_irq(1'b0, "R3 irq stays low when disabled");
      wr(0, 32'hF);
      wr(2, 32'hF);
      rd(0, 32'h4, "R3 writes to read-only words ignored");

      // R4 / R2 enable
      wr(1, 32'hA5A0_000F);
      rd(1, 32'hA5A0_000F, "R2 enable read back");
      rd(2, 32'h4, "R4 masked equals raw and enable");
      chk_irq(1'b1, "R4 irq from masked bit");

      // R5 clear
      wr(3, 32'hB);
      rd(0, 32'h4, "R5 zero bits leave status alone");
      wr(3, 32'h4);
      rd(0, 32'h0, "R5 clear drops bit");
      chk_irq(1'b0, "R5 irq low after clear");
      rd(3, 32'h0, "R2 clear word reads zero");

      // R8 / R6 frame end with crop disabled
      cap = 1'b1; crop = 1'b0; vs_end = 1'b1;
      set_vs(1'b0);
      rd(0, 32'h4, "R8 no frame done without crop");
      wr(3, 32'hF);
      crop = 1'b1;
      set_vs(1'b1);
      rd(0, 32'h0, "R6 end mode ignores frame start");
      set_vs(1'b0);
      rd(0, 32'h5, "R8 frame done with capture and crop");
      chk_irq(1'b1, "R8 irq from frame done");
      wr(3, 32'hF);
      cap = 1'b0;
      set_vs(1'b1);
      set_vs(1'b0);
      rd(0, 32'h4, "R8 no frame done without capture");
      wr(3, 32'hF);

      // R7 horizontal sync
      set_hs(1'b1);
      rd(0, 32'h8, "R7 hsync rise at line start");
      wr(3, 32'h8);
      idle(20);
      rd(0, 32'h0, "R7 held level gives one event");
      set_hs(1'b0);
      rd(0, 32'h0, "R7 start mode ignores line end");
      hs_end = 1'b1;
      set_hs(1'b1);
      rd(0, 32'h0, "R7 end mode ignores line start");
      set_hs(1'b0);
      rd(0, 32'h8, "R7 hsync fall at line end");
      wr(3, 32'hF);

      // R9 overrun
      pulse_ovr();
      rd(0, 32'h0, "R9 overrun ignored without capture");
      cap = 1'b1;
      pulse_ovr();
      rd(0, 32'h2, "R9 overrun recorded with capture");
      wr(1, 32'h4);
      rd(2, 32'h0, "R4 masked off by enable");
      chk_irq(1'b0, "R4 irq masked off");
      wr(1, 32'h2);
      rd(2, 32'h2, "R4 overrun masked through");
      chk_irq(1'b1, "R4 irq from overrun");

      // R10 event and clear together
      @(negedge clk);
      ovr_pulse = 1'b1;
      we = 1'b1; addr = AW'(3); wdata = 32'h2;
      @(negedge clk);
      ovr_pulse = 1'b0;
      we = 1'b0;
      rd(0, 32'h2, "R10 event beats clear");
      wr(3, 32'h2);
      rd(0, 32'h0, "R10 later clear takes effect");
      chk_irq(1'b0, "R10 irq low at end");

      idle(3);
      finished = 1'b1;
      summary();
      $finish;
   end
endmodule